// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block is the input half of a general-purpose I/O port with sixteen pins by default. Each pin level first passes through a two-stage synchronizer. A pin is accepted only when it is configured as an input and its input enable is set. For an accepted pin, the block copies the synchronized level into its input data bit. It also compares the new level with the previous one to decide whether the pin raises an interrupt.

Each pin picks one of three trigger modes from two configuration bits:

- **Level mode:** the pin's interrupt state is held for as long as the condition lasts.
- **Single-edge mode:** a transition in one direction produces a one-cycle pulse.
- **Any-edge mode:** a transition in either direction produces a one-cycle pulse.

A polarity bit inverts both the active level and the active edge. The per-pin interrupt states are ANDed with two mask vectors and ORed into two interrupt lines. This lets a register bank steer any pin to either line, or to both.

All configuration inputs are plain levels held by the register bank. No port carries a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `gpio_pin_irq`

## Requirements
- R1: A pin whose output-enable bit is 1, or whose input-enable bit is 0, is ignored. Its data bit keeps its value, a level-mode interrupt state keeps its value, and an edge-mode pin produces no pulse.
- R2: For an accepted pin, `in_data_o` takes the pin level on the third rising clock edge after the pin changes. Two edges are spent in the synchronizer and one in the data register.
- R3: With trig_edge=1 and trig_any=1, every change of an accepted pin's level, rising or falling, produces an interrupt pulse.
- R4: With trig_edge=1 and trig_any=0, polarity 0 selects rising edges only and polarity 1 selects falling edges only. The opposite edge produces no pulse.
- R5: An edge interrupt appears in `irq_state_o` for exactly one clock cycle, registered in the same cycle that the data bit updates.
- R6: With trig_edge=0 (level mode) and the pin accepted, the interrupt state is 1 while the synchronized level differs from the polarity bit (polarity 0 means active high, 1 means active low). The state returns to 0 once the condition goes away.
- R7: `irq_a_o` is the OR over all pins of (interrupt state AND mask A), and `irq_b_o` is the same with mask B. Both follow a mask change combinationally, in the same cycle.
- R8: While reset is asserted, the data bits, the interrupt states and both interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | PINS | Raw pin levels, asynchronous to clk |
| cfg_out_en_i | input | PINS | 1 = pin is an output; it is then ignored here |
| cfg_in_en_i | input | PINS | 1 = input buffer enabled |
| cfg_trig_edge_i | input | PINS | 0 = level mode, 1 = edge mode |
| cfg_trig_any_i | input | PINS | In edge mode: 1 = both edges |
| cfg_polarity_i | input | PINS | 1 = active low / falling edge |
| cfg_mask_a_i | input | PINS | Pins routed to line A |
| cfg_mask_b_i | input | PINS | Pins routed to line B |
| in_data_o | output | PINS | Last accepted synchronized level per pin |
| irq_state_o | output | PINS | Per-pin interrupt state |
| irq_a_o | output | 1 | Masked interrupt line A |
| irq_b_o | output | 1 | Masked interrupt line B |

## Verification
The hardest situation to reach is a level interrupt that must stay asserted after its pin has been blocked while the pin itself moves. To reach it, the stimulus first raises an accepted level-mode pin. It then clears that pin's input enable and drops the pin level. Finally it checks that both the data bit and the interrupt state keep their earlier values, and that the masks still steer that held state onto the lines. Edge pulses are sampled exactly at the cycle the synchronizer latency predicts, and again one cycle later, so a pulse that is stretched or shifted is caught.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'd0,
    SENSE_ONE   = 2'd1,
    SENSE_ANY   = 2'd2
  } sense_e;

  function automatic sense_e decode_sense(input logic trig_edge, input logic trig_any);
    if (!trig_edge)    return SENSE_LEVEL;
    else if (trig_any) return SENSE_ANY;
    else               return SENSE_ONE;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[LAST];
endmodule

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_i,
  input  logic out_en_i,
  input  logic in_en_i,
  input  logic trig_edge_i,
  input  logic trig_any_i,
  input  logic pol_i,
  output logic lvl_o,
  output logic irq_o
);
  logic   lvl_q, irq_q, lvl_d, irq_d;
  logic   accept, rise, fall;
  sense_e mode;

  assign accept = !out_en_i && in_en_i;
  assign mode   = decode_sense(trig_edge_i, trig_any_i);
  assign rise   = smp_i && !lvl_q;
  assign fall   = !smp_i && lvl_q;

  always_comb begin
    lvl_d = accept ? smp_i : lvl_q;
    unique case (mode)
      SENSE_LEVEL: irq_d = accept ? (smp_i ^ pol_i) : irq_q;
      SENSE_ONE:   irq_d = accept && (pol_i ? fall : rise);
      SENSE_ANY:   irq_d = accept && (rise || fall);
      default:     irq_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      irq_q <= irq_d;
    end
  end

  assign lvl_o = lvl_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic [WIDTH-1:0] mask_a_i,
  input  logic [WIDTH-1:0] mask_b_i,
  output logic             line_a_o,
  output logic             line_b_o
);
  assign line_a_o = |(state_i & mask_a_i);
  assign line_b_o = |(state_i & mask_b_i);
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq #(
  parameter int PINS        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_i,
  input  logic [PINS-1:0] cfg_out_en_i,
  input  logic [PINS-1:0] cfg_in_en_i,
  input  logic [PINS-1:0] cfg_trig_edge_i,
  input  logic [PINS-1:0] cfg_trig_any_i,
  input  logic [PINS-1:0] cfg_polarity_i,
  input  logic [PINS-1:0] cfg_mask_a_i,
  input  logic [PINS-1:0] cfg_mask_b_i,
  output logic [PINS-1:0] in_data_o,
  output logic [PINS-1:0] irq_state_o,
  output logic            irq_a_o,
  output logic            irq_b_o
);
  logic [PINS-1:0] pin_smp;

  gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pin_i),
    .q_o  (pin_smp)
  );

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    gpio_pin_sense u_sense (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_i      (pin_smp[p]),
      .out_en_i   (cfg_out_en_i[p]),
      .in_en_i    (cfg_in_en_i[p]),
      .trig_edge_i(cfg_trig_edge_i[p]),
      .trig_any_i (cfg_trig_any_i[p]),
      .pol_i      (cfg_polarity_i[p]),
      .lvl_o      (in_data_o[p]),
      .irq_o      (irq_state_o[p])
    );
  end

  gpio_irq_merge #(.WIDTH(PINS)) u_merge (
    .state_i (irq_state_o),
    .mask_a_i(cfg_mask_a_i),
    .mask_b_i(cfg_mask_b_i),
    .line_a_o(irq_a_o),
    .line_b_o(irq_b_o)
  );
endmodule

// File: rtl/gpio_pin_irq_chk.sv
module gpio_pin_irq_chk #(
  parameter int PINS = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PINS-1:0] smp,
  input logic [PINS-1:0] out_en,
  input logic [PINS-1:0] in_en,
  input logic [PINS-1:0] trig_edge,
  input logic [PINS-1:0] pol,
  input logic [PINS-1:0] data,
  input logic [PINS-1:0] irq_state,
  input logic            irq_a,
  input logic            irq_b
);
  logic            armed;
  logic [PINS-1:0] acc;

  assign acc = ~out_en & in_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_blocked_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (((data ^ $past(data)) & $past(~acc)) == '0));

  p_data_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (((data ^ $past(smp)) & $past(acc)) == '0));

  p_edge_needs_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((irq_state & $past(trig_edge) & ~(data ^ $past(data))) == '0));

  p_level_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (((irq_state ^ $past(smp ^ pol)) & $past(acc & ~trig_edge)) == '0));

  p_quiet_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_state == '0) |-> (!irq_a && !irq_b));
endmodule

bind gpio_pin_irq gpio_pin_irq_chk #(.PINS(PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp      (pin_smp),
  .out_en   (cfg_out_en_i),
  .in_en    (cfg_in_en_i),
  .trig_edge(cfg_trig_edge_i),
  .pol      (cfg_polarity_i),
  .data     (in_data_o),
  .irq_state(irq_state_o),
  .irq_a    (irq_a_o),
  .irq_b    (irq_b_o)
);

// File: tb/tb_gpio_pin_irq.sv
module tb_gpio_pin_irq;
  localparam int PINS = 16;

  logic            clk   = 1'b0;
  logic            rst_n = 1'b0;
  logic [PINS-1:0] pins  = '0;
  logic [PINS-1:0] oen   = '0;
  logic [PINS-1:0] ien   = '0;
  logic [PINS-1:0] tedg  = '0;
  logic [PINS-1:0] tany  = '0;
  logic [PINS-1:0] pol   = '0;
  logic [PINS-1:0] ma    = '0;
  logic [PINS-1:0] mb    = '0;
  logic [PINS-1:0] data, irq;
  logic            la, lb;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_pin_irq #(.PINS(PINS), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins),
    .cfg_out_en_i(oen), .cfg_in_en_i(ien), .cfg_trig_edge_i(tedg),
    .cfg_trig_any_i(tany), .cfg_polarity_i(pol),
    .cfg_mask_a_i(ma), .cfg_mask_b_i(mb),
    .in_data_o(data), .irq_state_o(irq), .irq_a_o(la), .irq_b_o(lb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // pin change reaches data/irq on the third rising edge
  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8 data", data, 0);
    chk("R8 irq", irq, 0);
    chk("R8 lines", {la, lb}, 0);
    rst_n = 1'b1;
    ien = '1;
    @(negedge clk);
  endtask

  task automatic t_latency();
    pins[9] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2 before third edge", data[9], 0);
    @(negedge clk);
    chk("R2 after third edge", data[9], 1);
    chk("R6 level irq pin9", irq[9], 1);
    pins[9] = 1'b0;
    settle();
  endtask

  task automatic t_level();
    ma = 16'h0001;
    pins[0] = 1'b1;
    settle();
    chk("R2 data0", data[0], 1);
    chk("R6 active high", irq[0], 1);
    chk("R7 line a", la, 1);
    repeat (2) @(negedge clk);
    chk("R6 held", irq[0], 1);
    pins[0] = 1'b0;
    settle();
    chk("R6 deassert", irq[0], 0);
    chk("R7 line a drop", la, 0);
    pol[1] = 1'b1;
    settle();
    chk("R6 active low", irq[1], 1);
    pol[1] = 1'b0;
    settle();
    chk("R6 active low gone", irq[1], 0);
    ma = '0;
  endtask

  task automatic t_edge_single();
    tedg[2] = 1'b1;
    mb = 16'h0004;
    pins[2] = 1'b1;
    settle();
    chk("R4 rising pulse", irq[2], 1);
    chk("R7 line b pulse", lb, 1);
    @(negedge clk);
    chk("R5 one cycle", irq[2], 0);
    pins[2] = 1'b0;
    settle();
    chk("R4 falling ignored", irq[2], 0);
    chk("R2 data2", data[2], 0);
    tedg[3] = 1'b1;
    pol[3] = 1'b1;
    @(negedge clk);
    pins[3] = 1'b1;
    settle();
    chk("R4 rising ignored pol1", irq[3], 0);
    pins[3] = 1'b0;
    settle();
    chk("R4 falling pulse pol1", irq[3], 1);
    @(negedge clk);
    chk("R5 one cycle pol1", irq[3], 0);
    mb = '0;
  endtask

  task automatic t_both();
    tedg[4] = 1'b1;
    tany[4] = 1'b1;
    @(negedge clk);
    pins[4] = 1'b1;
    settle();
    chk("R3 rise pulse", irq[4], 1);
    @(negedge clk);
    chk("R5 both one cycle", irq[4], 0);
    pins[4] = 1'b0;
    settle();
    chk("R3 fall pulse", irq[4], 1);
    @(negedge clk);
    chk("R5 both fall one cycle", irq[4], 0);
  endtask

  task automatic t_blocked();
    oen[5] = 1'b1;
    ien[6] = 1'b0;
    @(negedge clk);
    pins[5] = 1'b1;
    pins[6] = 1'b1;
    settle();
    chk("R1 output pin data", data[5], 0);
    chk("R1 output pin irq", irq[5], 0);
    chk("R1 disabled pin data", data[6], 0);
    chk("R1 disabled pin irq", irq[6], 0);
    pins[7] = 1'b1;
    settle();
    chk("R6 pin7 active", irq[7], 1);
    ien[7] = 1'b0;
    @(negedge clk);
    pins[7] = 1'b0;
    settle();
    chk("R1 level irq held", irq[7], 1);
    chk("R1 data held", data[7], 1);
    tedg[8] = 1'b1;
    tany[8] = 1'b1;
    oen[8] = 1'b1;
    @(negedge clk);
    pins[8] = 1'b1;
    settle();
    chk("R1 no edge pulse", irq[8], 0);
  endtask

  task automatic t_mask();
    // pin7 interrupt state is still held from t_blocked
    ma = '0;
    mb = '0;
    #1;
    chk("R7 masked off", {la, lb}, 0);
    ma = 16'h0080;
    #1;
    chk("R7 mask a only", {la, lb}, 2'b10);
    mb = 16'h0080;
    #1;
    chk("R7 both lines", {la, lb}, 2'b11);
    ma = 16'h7F7F;
    #1;
    chk("R7 other bits", {la, lb}, 2'b01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_level();
    t_edge_single();
    t_both();
    t_blocked();
    t_mask();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule